// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a serial slave on a two-wire bus (SCL clock, SDA open-drain data). It gives a bus master access to a bank of ten byte-wide registers. Both bus lines are resynchronised to a fast system clock, and the block finds START and STOP conditions and clock edges on the synchronised copies. It answers to one fixed 7-bit device address. On a write transfer, the first byte after the address loads an internal register pointer. Each later byte is stored at the pointer, and the pointer then moves on. On a read transfer, the block sends bytes from the pointer onward. It advances the pointer only when the master acknowledges a byte.

A master can do a random read: it writes the pointer, issues a repeated START and reads. It can also do a current-address read, which skips the pointer write and continues from wherever the last transfer left the pointer. A power-fail input overrides the bus. While it is high the block drops any transfer in progress, clears the pointer, releases SDA and ignores the bus completely. The register contents are kept.

Top module: `twi_regbank_slave`

## Requirements
- R1: After reset, sda_oe is low, all ten registers hold 00h and the pointer is 00h.
- R2: A byte after START whose upper seven bits equal 1101000 is acknowledged by driving SDA low during the ninth clock. Bit 0 of that byte selects the direction: 0 is write (D0h) and 1 is read (D1h).
- R3: If the device address does not match, SDA is never driven. All following bytes up to the next START are ignored, so no register and no pointer value changes.
- R4: In a write transfer, the first data byte loads the pointer and is acknowledged. Each later byte is acknowledged and written to the register at the pointer when its acknowledge is driven, and the pointer then advances by one.
- R5: The pointer wraps from 09h to 00h. A pointer byte of 0Ah or above loads 00h.
- R6: A random read (pointer write, repeated START, read address) returns the register at the written pointer, most significant bit first.
- R7: During reads the pointer advances only when the master acknowledges. After a master NACK, the slave releases SDA and waits for STOP or START. A later current-address read begins at the byte that was NACKed.
- R8: A read with no pointer write starts at the pointer left by the previous transfer.
- R9: Raising pwr_fail aborts the transfer in progress within one cycle. It clears the pointer to 00h and releases SDA. A partly received byte is discarded, and the registers keep their contents.
- R10: While pwr_fail is high, bus activity is ignored. No byte is acknowledged and nothing is written.
- R11: A STOP returns the slave to idle, and a START in any state restarts the address phase. A data byte cut off by STOP is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Supply-failure indication; aborts and blocks bus access while high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
The hardest situations to reach from the ports are a power failure that lands in the middle of a data byte, and a STOP that cuts off a byte. Neither one leaves a visible output on its own. The stimulus stops a bus write after a few bits and raises pwr_fail there, or issues a STOP there. It then runs a full transfer that must go unacknowledged, and reads the whole bank back with a current-address read. That read shows at the pins that the pointer was cleared or kept and that no partial byte was stored. Seeded random writes and reads at random pointers and lengths, including out-of-range pointer bytes and wraparound, are then checked against a bench model of the bank.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int BITCNT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_RX_PTR,
    ST_ACK_PTR,
    ST_RX_DATA,
    ST_ACK_DATA,
    ST_TX,
    ST_MACK
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
  assign sda_lvl   = sda_s;
endmodule

// File: rtl/twi_reg_file.sv
module twi_reg_file #(
  parameter int NUM_REGS = 10,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))
        regs[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         NUM_REGS    = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import twi_pkg::*;

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

  // Pointer arithmetic, kept in functions so the bench can restate it.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_load(input logic [BYTE_W-1:0] b);
    return (b < BYTE_W'(NUM_REGS)) ? b[PTR_W-1:0] : '0;
  endfunction

  // Named internal events, also used by the checker.
  logic scl_rise, scl_fall, evt_start, evt_stop, sda_s;
  logic wr_en, st_is_idle;
  logic [BYTE_W-1:0] rd_data;

  twi_state_e        st_q;
  logic [BITCNT_W-1:0] bit_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              rw_q, mack_q, oe_q;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (evt_start),
    .stop_evt  (evt_stop),
    .sda_lvl   (sda_s)
  );

  twi_reg_file #(.NUM_REGS(NUM_REGS), .ADDR_W(PTR_W), .DATA_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (ptr_q),
    .wr_data (sh_q),
    .rd_addr (ptr_q),
    .rd_data (rd_data)
  );

  assign wr_en = (st_q == ST_RX_DATA) && scl_fall && (bit_q == LAST_BIT)
                 && !pwr_fail && !evt_start && !evt_stop;
  assign st_is_idle = (st_q == ST_IDLE);
  assign sda_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (pwr_fail) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      ptr_q <= '0;
      oe_q  <= 1'b0;
    end else if (evt_start) begin
      st_q  <= ST_ADDR;
      bit_q <= '0;
      oe_q  <= 1'b0;
    end else if (evt_stop) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_RX_PTR, ST_RX_DATA: begin
          if (scl_rise && bit_q != LAST_BIT) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            bit_q <= bit_q + 1'b1;
          end else if (scl_fall && bit_q == LAST_BIT) begin
            bit_q <= '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                rw_q <= sh_q[0];
                oe_q <= 1'b1;
                st_q <= ST_ACK_ADDR;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (st_q == ST_RX_PTR) begin
              ptr_q <= ptr_load(sh_q);
              oe_q  <= 1'b1;
              st_q  <= ST_ACK_PTR;
            end else begin
              ptr_q <= ptr_step(ptr_q);
              oe_q  <= 1'b1;
              st_q  <= ST_ACK_DATA;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_q  <= {rd_data[BYTE_W-2:0], 1'b0};
              oe_q  <= ~rd_data[BYTE_W-1];
              bit_q <= BITCNT_W'(1);
              st_q  <= ST_TX;
            end else begin
              oe_q  <= 1'b0;
              bit_q <= '0;
              st_q  <= ST_RX_PTR;
            end
          end
        end
        ST_ACK_PTR, ST_ACK_DATA: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            bit_q <= '0;
            st_q  <= ST_RX_DATA;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == LAST_BIT) begin
              oe_q <= 1'b0;
              st_q <= ST_MACK;
            end else begin
              oe_q  <= ~tx_q[BYTE_W-1];
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
            if (!sda_s) ptr_q <= ptr_step(ptr_q);
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_q  <= {rd_data[BYTE_W-2:0], 1'b0};
              oe_q  <= ~rd_data[BYTE_W-1];
              bit_q <= BITCNT_W'(1);
              st_q  <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twi_regbank_slave_chk.sv
module twi_regbank_slave_chk #(
  parameter int NUM_REGS = 10,
  parameter int PTR_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_fail,
  input logic             sda_oe,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             evt_start,
  input logic             evt_stop,
  input logic             wr_en,
  input logic             idle,
  input logic [PTR_W-1:0] ptr
);
  // R5: pointer never leaves the register range
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NUM_REGS);

  // R9: power failure clears pointer, releases SDA, goes idle
  p_pwrfail_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (ptr == '0) && !sda_oe && idle);

  // R3: an idle slave never pulls SDA
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  // R4: a register write coincides with the acknowledge being driven
  p_commit_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R11: STOP leaves the slave idle with SDA released
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stop && !pwr_fail) |=> idle && !sda_oe);

  // R2: SDA drive changes only after an SCL fall or a bus/power event
  p_oe_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(evt_start)
                          || $past(evt_stop) || $past(pwr_fail)));

  // R7: pointer moves only on an SCL edge or a power failure
  p_ptr_moves_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> ($past(scl_fall) || $past(scl_rise) || $past(pwr_fail)));
endmodule

bind twi_regbank_slave twi_regbank_slave_chk #(
  .NUM_REGS (NUM_REGS),
  .PTR_W    (PTR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_fail  (pwr_fail),
  .sda_oe    (sda_oe),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .evt_start (evt_start),
  .evt_stop  (evt_stop),
  .wr_en     (wr_en),
  .idle      (st_is_idle),
  .ptr       (ptr_q)
);

// File: tb/twi_regbank_slave_test.sv
module twi_regbank_slave_test;
  localparam int Q = 10;
  localparam int NREG = 10;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n, pwr_fail, scl_m, sda_m;
  logic sda_oe, sda_line;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] mreg [NREG];
  int mptr;
  logic [7:0] wbuf [8];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twi_regbank_slave uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_fail (pwr_fail),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe)
  );

  function automatic int m_step(input int p);
    return (p + 1) % NREG;
  endfunction

  function automatic int m_load(input logic [7:0] b);
    return (int'(b) < NREG) ? int'(b) : 0;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    scl_m = 1'b0; tick(Q);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
  endtask

  task automatic bit_in(output logic b);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~give_ack);
  endtask

  task automatic do_write(input logic [7:0] pb, input int n, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD0, a); check("R2 write address ack", a, 1);
    send_byte(pb, a);    check("R4 pointer ack", a, 1);
    mptr = m_load(pb);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); check(tag, a, 1);
      mreg[mptr] = wbuf[k];
      mptr = m_step(mptr);
    end
    bus_stop();
  endtask

  task automatic do_read(input bit rnd, input logic [7:0] pb, input int n, input string tag);
    logic a;
    logic [7:0] d;
    bus_start();
    if (rnd) begin
      send_byte(8'hD0, a); check("R2 write address ack", a, 1);
      send_byte(pb, a);    check("R4 pointer ack", a, 1);
      mptr = m_load(pb);
      bus_start();
    end
    send_byte(8'hD1, a); check("R2 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(tag, d, mreg[mptr]);
      if (k != n - 1) mptr = m_step(mptr);
    end
    bus_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    void'($urandom(32'd8191));
    scl_m = 1'b1; sda_m = 1'b1; pwr_fail = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
    mptr = 0;
    tick(5);
    check("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    check("R1 sda_oe after reset", sda_oe, 0);
    do_read(0, 8'h00, NREG, "R1 reset contents");

    // R5: wrap 09h -> 00h during a write, then random read across the wrap
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    do_write(8'h08, 3, "R5 wrap write ack");
    do_read(1, 8'h08, 3, "R6 R5 random read across wrap");

    // R5: out-of-range pointer loads 00h
    wbuf[0] = 8'h5A;
    do_write(8'h0C, 1, "R5 out-of-range pointer write ack");
    do_read(1, 8'h00, 1, "R5 out-of-range landed at 00h");

    // R3: wrong addresses are ignored
    bus_start();
    send_byte(8'hA0, a); check("R3 no ack on mismatch", a, 0);
    send_byte(8'h02, a); check("R3 following byte ignored", a, 0);
    send_byte(8'h66, a); check("R3 following byte ignored", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD2, a); check("R3 one-bit mismatch", a, 0);
    bus_stop();
    do_read(0, 8'h00, NREG, "R3 R8 bank and pointer unchanged");

    // R7: NACKed byte is re-read by the next current-address read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(8'h04, 4, "R4 data ack");
    do_read(1, 8'h04, 1, "R7 single byte NACK");
    do_read(0, 8'h00, 1, "R7 resume at NACKed byte");
    do_read(0, 8'h00, 3, "R7 R8 ACKed bytes advance");

    // R9/R10: power failure in the middle of a data byte
    bus_start();
    send_byte(8'hD0, a); check("R2 write address ack", a, 1);
    send_byte(8'h03, a); check("R4 pointer ack", a, 1);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    pwr_fail = 1'b1;
    tick(4);
    check("R9 SDA released on power fail", sda_oe, 0);
    bus_start();
    send_byte(8'hD0, a); check("R10 address ignored in power fail", a, 0);
    send_byte(8'h05, a); check("R10 pointer ignored in power fail", a, 0);
    send_byte(8'h77, a); check("R10 data ignored in power fail", a, 0);
    bus_stop();
    pwr_fail = 1'b0;
    tick(10);
    mptr = 0;
    do_read(0, 8'h00, NREG, "R9 pointer cleared, bank kept");

    // R11: STOP in the middle of a data byte
    bus_start();
    send_byte(8'hD0, a); check("R2 write address ack", a, 1);
    send_byte(8'h02, a); check("R4 pointer ack", a, 1);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    bus_stop();
    mptr = 2;
    do_read(0, 8'h00, 2, "R11 cut byte not written");

    // R11: repeated START during a write turns into a read
    bus_start();
    send_byte(8'hD0, a); check("R2 write address ack", a, 1);
    send_byte(8'h06, a); check("R4 pointer ack", a, 1);
    bit_out(1'b1); bit_out(1'b1);
    mptr = 6;
    do_read(0, 8'h00, 2, "R11 restart after START");

    // Seeded random mix
    for (int it = 0; it < 30; it++) begin
      int op, n;
      logic [7:0] pb;
      op = int'($urandom_range(0, 2));
      n  = int'($urandom_range(1, 4));
      pb = 8'($urandom_range(0, 11));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      case (op)
        0: do_write(pb, n, "R4 random write ack");
        1: do_read(1, pb, n, "R6 random read");
        default: do_read(0, 8'h00, n, "R8 current-address read");
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule